// File: doc/BRIEF.md
# BFloat16 2x2 Matrix Multiply-Accumulate

This block is a vector datapath unit that runs a small matrix multiply-accumulate on every 128-bit segment of a vector operand. In each segment the first source is read as a 2x4 matrix of bfloat16 values, with two 32-bit words per row. The second source is read as a 4x2 matrix of bfloat16 values, with two 32-bit words per column, so that each column's four elements are contiguous. Their product is added to a 2x2 tile of single-precision accumulators, and the 2x2 single-precision tile that results replaces the accumulator tile.

A request is issued with a one-cycle `start` strobe. It carries the accumulator vector, the two sources, an element-size code, a width flag and the count of active segments. The unit copies the accumulator into a working vector and updates that vector in place, one segment per clock. Each segment's four results are computed from that segment's original words before any of them is written back. Segments above the active count are then zeroed, and `done` pulses once. An illegal request is rejected at once with `done` and `illegal` raised together.

The arithmetic flushes subnormals to zero, rounds every addition to odd and returns a single default quiet NaN.

Top module: `bf16_mmla`

## Requirements
- R1: After reset, `result` is all zero and `done` and `illegal` are low.
- R2: For a legal request, result word 2i+k (i,k in {0,1}, word w at bits 32w+31:32w of a segment) equals accumulator word 2i+k plus two dot-add steps. The first step uses first-source word 2i with second-source word 2k. The second step uses first-source word 2i+1 with second-source word 2k+1. In each word, bits 15:0 hold the first bfloat16 element and bits 31:16 hold the second. Elements pair up by position.
- R3: For a legal request with N active segments, `done` is high for exactly one cycle, beginning after the (N+1)-th rising edge that follows the edge accepting `start`.
- R4: Each segment's four results depend only on that segment's original accumulator and source words, even though they are written into the same storage that held the accumulator.
- R5: On completion, every segment at or above `num_segs` (up to SEGS_MAX) reads as zero.
- R6: A request is illegal when `elem_size` is not 2'b01, when `wide` is 0, when `num_segs` is 0, or when `num_segs` exceeds SEGS_MAX. In that case `done` and `illegal` are both high for one cycle right after the accepting edge, and `result` is left unchanged.
- R7: Subnormal inputs are treated as zero, and a product or sum below the normal range becomes a zero of the same sign.
- R8: An inexact addition has its result truncated, with the lowest fraction bit forced to 1 (round to odd).
- R9: Any NaN operand, infinity times zero, or the sum of opposite infinities gives 32'h7FC00000.
- R10: A finite result above the largest normal magnitude becomes the largest finite value of the same sign (32'h7F7FFFFF when positive).
- R11: A `start` that arrives while a request is in progress is ignored, and the running request completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted when idle |
| elem_size | input | 2 | Element size code, 2'b01 = 16-bit |
| wide | input | 1 | 1 = full 128-bit vector width |
| num_segs | input | $clog2(SEGS_MAX+1) | Number of active 128-bit segments |
| acc_in | input | 128*SEGS_MAX | Accumulator / destination vector |
| src_a | input | 128*SEGS_MAX | First source (row-major 2x4 per segment) |
| src_b | input | 128*SEGS_MAX | Second source (column-major 4x2 per segment) |
| result | output | 128*SEGS_MAX | Working / result vector |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Raised with `done` when a request was rejected |

## Verification
In every segment-update cycle, the write-back of four results overlaps the read of the accumulator words those results replace. A wrong read-after-write order would therefore feed updated values into later lanes. The bench provokes this with multi-segment requests whose accumulator words all differ. It compares every lane against an integer model that only ever uses the original values. A second overlap is the arrival of a new `start` while a request is in progress. The bench issues one with different operands mid-run and judges that the finished vector still matches the first request.

// File: rtl/bf16_mmla.sv
module bf16_mmla #(
  parameter int SEGS_MAX = 4,
  localparam int VW = 128 * SEGS_MAX,
  localparam int CW = $clog2(SEGS_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    elem_size,
  input  logic          wide,
  input  logic [CW-1:0] num_segs,
  input  logic [VW-1:0] acc_in,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  output logic [VW-1:0] result,
  output logic          done,
  output logic          illegal
);
  localparam logic [31:0] QNAN = 32'h7FC00000;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_CLEAR} state_t;

  state_t        st;
  logic [CW-1:0] seg, nseg_q;
  logic [VW-1:0] a_q, b_q, work;
  logic [127:0]  seg_out;
  logic          bad_req;

  function automatic logic [31:0] fmul(input logic [15:0] a, input logic [15:0] b);
    logic s, an, bn, ai, bi, az, bz;
    logic [15:0] pr;
    int e;
    s  = a[15] ^ b[15];
    an = (a[14:7] == 8'hFF) && (a[6:0] != 7'h0);
    bn = (b[14:7] == 8'hFF) && (b[6:0] != 7'h0);
    ai = (a[14:7] == 8'hFF) && (a[6:0] == 7'h0);
    bi = (b[14:7] == 8'hFF) && (b[6:0] == 7'h0);
    az = (a[14:7] == 8'h00);
    bz = (b[14:7] == 8'h00);
    if (an || bn || (ai && bz) || (bi && az)) return QNAN;
    if (ai || bi) return {s, 8'hFF, 23'h0};
    if (az || bz) return {s, 31'h0};
    pr = 16'({1'b1, a[6:0]}) * 16'({1'b1, b[6:0]});
    e = int'(a[14:7]) + int'(b[14:7]) - 127 + (pr[15] ? 1 : 0);
    if (e <= 0) return {s, 31'h0};
    if (e >= 255) return {s, 8'hFE, 23'h7FFFFF};
    return pr[15] ? {s, e[7:0], pr[14:0], 8'h0} : {s, e[7:0], pr[13:0], 9'h0};
  endfunction

  function automatic logic [31:0] fadd(input logic [31:0] x, input logic [31:0] y);
    logic xn, yn, xi, yi, xz, yz, st_b, inex;
    logic [31:0] hi, lo;
    logic [47:0] ma, mb, bs;
    logic [48:0] sum;
    logic [23:0] m24;
    int d, p, e;
    xn = (x[30:23] == 8'hFF) && (x[22:0] != 23'h0);
    yn = (y[30:23] == 8'hFF) && (y[22:0] != 23'h0);
    xi = (x[30:23] == 8'hFF) && (x[22:0] == 23'h0);
    yi = (y[30:23] == 8'hFF) && (y[22:0] == 23'h0);
    xz = (x[30:23] == 8'h00);
    yz = (y[30:23] == 8'h00);
    if (xn || yn || (xi && yi && (x[31] != y[31]))) return QNAN;
    if (xi) return x;
    if (yi) return y;
    if (xz && yz) return {x[31] & y[31], 31'h0};
    if (xz) return y;
    if (yz) return x;
    if (x[30:0] >= y[30:0]) begin hi = x; lo = y; end
    else begin hi = y; lo = x; end
    d  = int'(hi[30:23]) - int'(lo[30:23]);
    ma = {1'b1, hi[22:0], 24'h0};
    mb = {1'b1, lo[22:0], 24'h0};
    if (d > 47) begin
      bs = 48'h0; st_b = 1'b1;
    end else begin
      bs = mb >> d;
      st_b = |(mb & ((48'd1 << d) - 48'd1));
    end
    if (hi[31] == lo[31]) sum = {1'b0, ma} + {1'b0, bs};
    else sum = {1'b0, ma} - {1'b0, bs} - {48'h0, st_b};
    if (sum == 49'h0) return 32'h0;
    p = 0;
    for (int i = 0; i < 49; i++) if (sum[i]) p = i;
    e = int'(hi[30:23]) + p - 47;
    if (p >= 23) begin
      m24  = 24'(sum >> (p - 23));
      inex = st_b | (|(sum & ((49'd1 << (p - 23)) - 49'd1)));
    end else begin
      m24  = 24'(sum << (23 - p));
      inex = st_b;
    end
    if (e <= 0) return {hi[31], 31'h0};
    if (e >= 255) return {hi[31], 8'hFE, 23'h7FFFFF};
    return {hi[31], e[7:0], m24[22:1], m24[0] | inex};
  endfunction

  function automatic logic [31:0] dot_add(input logic [31:0] acc, input logic [31:0] u,
                                          input logic [31:0] v);
    return fadd(acc, fadd(fmul(u[15:0], v[15:0]), fmul(u[31:16], v[31:16])));
  endfunction

  always_comb begin
    seg_out = '0;
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < 2; k++)
        seg_out[32*(2*i+k) +: 32] =
          dot_add(dot_add(work[128*int'(seg) + 32*(2*i+k) +: 32],
                          a_q[128*int'(seg) + 32*(2*i) +: 32],
                          b_q[128*int'(seg) + 32*(2*k) +: 32]),
                  a_q[128*int'(seg) + 32*(2*i+1) +: 32],
                  b_q[128*int'(seg) + 32*(2*k+1) +: 32]);
  end

  assign bad_req = (elem_size != 2'b01) || !wide || (num_segs == '0) ||
                   (int'(num_segs) > SEGS_MAX);
  assign result = work;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      seg     <= '0;
      nseg_q  <= '0;
      a_q     <= '0;
      b_q     <= '0;
      work    <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            if (bad_req) begin
              done    <= 1'b1;
              illegal <= 1'b1;
            end else begin
              work   <= acc_in;
              a_q    <= src_a;
              b_q    <= src_b;
              nseg_q <= num_segs;
              seg    <= '0;
              st     <= S_RUN;
            end
          end
        S_RUN: begin
          work[128*int'(seg) +: 128] <= seg_out;
          if (seg == nseg_q - CW'(1)) st <= S_CLEAR;
          else seg <= seg + CW'(1);
        end
        default: begin
          for (int s = 0; s < SEGS_MAX; s++)
            if (s >= int'(nseg_q)) work[128*s +: 128] <= '0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  logic tail_nz;
  always_comb begin
    tail_nz = 1'b0;
    for (int s = 0; s < SEGS_MAX; s++)
      if (s >= int'(nseg_q) && work[128*s +: 128] != '0) tail_nz = 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> done); // R6
  AST_ILLEGAL_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> $stable(result)); // R6
  AST_TAIL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) (done && !illegal) |-> !tail_nz); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (st != S_IDLE && start) |=> ($stable(a_q) && $stable(nseg_q))); // R11
endmodule

// File: tb/bf16_mmla_test.sv
module bf16_mmla_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEGS = 4;
  localparam int VW = 128 * SEGS;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b1, done, illegal;
  logic [1:0] elem_size = 2'b01;
  logic [2:0] num_segs = 3'd1;
  logic [VW-1:0] acc_in = '0, src_a = '0, src_b = '0, result;

  int checks = 0, errors = 0;
  int acc_i[SEGS][4];
  int a_i[SEGS][4][2];
  int b_i[SEGS][4][2];
  logic [VW-1:0] av, sa, sb, expv, got, last;
  int cyc;
  logic ill, pulse_ok;

  bf16_mmla #(.SEGS_MAX(SEGS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .elem_size(elem_size), .wide(wide),
    .num_segs(num_segs), .acc_in(acc_in), .src_a(src_a), .src_b(src_b),
    .result(result), .done(done), .illegal(illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] i2f(input int v);
    int mag, p;
    if (v == 0) return 32'h0;
    mag = (v < 0) ? -v : v;
    p = 0;
    for (int i = 0; i < 31; i++) if (mag[i]) p = i;
    return {v < 0, 8'(127 + p), 23'(mag << (23 - p))};
  endfunction

  function automatic logic [15:0] i2bf(input int v);
    logic [31:0] f;
    f = i2f(v);
    return f[31:16];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] g, input logic [VW-1:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, g, e);
    end
  endtask

  task automatic run_op(input logic [1:0] es, input logic wd, input logic [2:0] n,
                        input logic [VW-1:0] a0, input logic [VW-1:0] s0, input logic [VW-1:0] s1);
    @(negedge clk);
    elem_size = es; wide = wd; num_segs = n; acc_in = a0; src_a = s0; src_b = s1; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    got = result; ill = illegal;
    @(negedge clk);
    pulse_ok = !done;
  endtask

  task automatic gen(input int n);
    int val;
    av = '0; sa = '0; sb = '0; expv = '0;
    for (int s = 0; s < SEGS; s++)
      for (int w = 0; w < 4; w++) begin
        acc_i[s][w] = int'($urandom_range(2000000)) - 1000000;
        av[128*s + 32*w +: 32] = i2f(acc_i[s][w]);
        for (int e = 0; e < 2; e++) begin
          a_i[s][w][e] = int'($urandom_range(30)) - 15;
          b_i[s][w][e] = int'($urandom_range(30)) - 15;
          sa[128*s + 32*w + 16*e +: 16] = i2bf(a_i[s][w][e]);
          sb[128*s + 32*w + 16*e +: 16] = i2bf(b_i[s][w][e]);
        end
      end
    for (int s = 0; s < n; s++)
      for (int i = 0; i < 2; i++)
        for (int k = 0; k < 2; k++) begin
          val = acc_i[s][2*i+k];
          for (int w = 0; w < 2; w++)
            for (int e = 0; e < 2; e++)
              val += a_i[s][2*i+w][e] * b_i[s][2*k+w][e];
          expv[128*s + 32*(2*i+k) +: 32] = i2f(val);
        end
  endtask

  task automatic fp_case(input logic [31:0] nw, input logic [31:0] mw, input logic [31:0] aw,
                         input logic [31:0] ew, input string req);
    av = '0; sa = '0; sb = '0; expv = '0;
    for (int w = 0; w < 4; w++) begin
      av[32*w +: 32] = aw; sa[32*w +: 32] = nw; sb[32*w +: 32] = mw; expv[32*w +: 32] = ew;
    end
    run_op(2'b01, 1'b1, 3'd1, av, sa, sb);
    chk(got === expv, req, got, expv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(result === '0 && done === 1'b0 && illegal === 1'b0, "R1 reset state", result, '0);
    rst_n = 1'b1;

    // R2 R5 R3: single segment with a non-zero tail in the accumulator
    gen(1);
    run_op(2'b01, 1'b1, 3'd1, av, sa, sb);
    chk(got === expv, "R2/R5 one segment, tail zeroed", got, expv);
    chk(cyc == 2 && pulse_ok, "R3 latency one segment", VW'(cyc), VW'(2));

    // R4 R2 R3 R5: random multi-segment requests
    for (int t = 0; t < 24; t++) begin
      int n;
      n = 1 + int'($urandom_range(SEGS - 1));
      gen(n);
      run_op(2'b01, 1'b1, 3'(n), av, sa, sb);
      chk(got === expv && !ill, "R4 in-place segment update", got, expv);
      chk(cyc == n + 1 && pulse_ok, "R3 latency and single pulse", VW'(cyc), VW'(n + 1));
    end

    // R8 round to odd: 1.0 + 2^-30 twice
    fp_case(32'h0000_3800, 32'h0000_3800, 32'h3F80_0000, 32'h3F80_0001, "R8 round to odd");
    // R7 subnormal input flushed
    fp_case(32'h0000_0001, 32'h0000_3F80, 32'h4000_0000, 32'h4000_0000, "R7 subnormal input");
    // R7 underflowed product flushed
    fp_case(32'h0000_1C80, 32'h0000_1C80, 32'h0000_0000, 32'h0000_0000, "R7 underflow result");
    // R9 NaN operand and infinity times zero
    fp_case(32'h0000_7FC1, 32'h0000_3F80, 32'h3F80_0000, 32'h7FC0_0000, "R9 NaN operand");
    fp_case(32'h0000_7F80, 32'h0000_0000, 32'h3F80_0000, 32'h7FC0_0000, "R9 inf times zero");
    // R10 overflow saturates to largest finite
    fp_case(32'h0000_7F00, 32'h0000_7F00, 32'h0000_0000, 32'h7F7F_FFFF, "R10 overflow");

    // R6 illegal requests leave result unchanged
    last = result;
    gen(2);
    run_op(2'b10, 1'b1, 3'd2, av, sa, sb);
    chk(ill && cyc == 0 && got === last && pulse_ok, "R6 bad element size", got, last);
    run_op(2'b01, 1'b0, 3'd2, av, sa, sb);
    chk(ill && cyc == 0 && got === last, "R6 narrow vector", got, last);
    run_op(2'b01, 1'b1, 3'd0, av, sa, sb);
    chk(ill && cyc == 0 && got === last, "R6 zero segments", got, last);
    run_op(2'b01, 1'b1, 3'd5, av, sa, sb);
    chk(ill && cyc == 0 && got === last, "R6 too many segments", got, last);

    // R11 start while busy is ignored
    gen(SEGS);
    @(negedge clk);
    elem_size = 2'b01; wide = 1'b1; num_segs = 3'(SEGS); acc_in = av; src_a = sa; src_b = sb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    num_segs = 3'd1; acc_in = '0; src_a = ~sa; src_b = ~sb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    chk(result === expv && !illegal, "R11 start while busy ignored", result, expv);
    repeat (4) @(negedge clk);
    chk(result === expv && !done, "R11 no second request ran", result, expv);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule